// File: doc/BRIEF.md
# Serial ADC Lane Deserializer with Frame Alignment

This block turns the serial output of one high-speed ADC channel into parallel sample words. The ADC sends its bits over LVDS lanes, and data changes on both edges of a bit clock. A frame line runs beside the data lanes. The block samples the frame line as one more data input and uses it only to find where a word begins. The frame line never clocks any logic. All registers run on the bit clock. The only exception is the falling-edge capture flop in the input stage.

A static mode input selects how the sample is spread over the lanes. In one-wire mode, a single lane carries all 12 bits of a sample. In two-wire mode, the odd-indexed bits and the even-indexed bits travel on separate lanes. Each lane then delivers 6 bits per sample, and the block interleaves them again.

The word boundary that the block assumes can be moved one bit at a time with a bitslip pulse. Surrounding logic watches the alignment-error flag and pulses bitslip until the flag clears. The block serves one channel. A multi-channel converter uses one instance per channel.

Top module: `lvds_adc_deser`

## Requirements
- R1: Bit order on a lane. The bit present at the rising edge of the bit clock comes before the bit present at the following falling edge. Every lane sends the most significant bit of its share first.
- R2: One-wire mode (`two_wire_i` = 0). `lane0_i` carries all 12 sample bits, from bit 11 down to bit 0, over 6 bit-clock cycles. `lane1_i` has no effect on any output.
- R3: Two-wire mode (`two_wire_i` = 1). `lane0_i` carries sample bits 11, 9, 7, 5, 3, 1 in that order. `lane1_i` carries bits 10, 8, 6, 4, 2, 0 at the same times. A sample therefore takes 3 bit-clock cycles.
- R4: `valid_o` is high for exactly one cycle for each completed word. With no bitslip pulse, consecutive strobes are 6 cycles apart in one-wire mode and 3 cycles apart in two-wire mode.
- R5: Each word has an expected frame pattern. The frame line must be high for the first half of the word's bits on a lane and low for the second half. That is 6 high and 6 low in one-wire mode, and 3 high and 3 low in two-wire mode. The boundary is therefore the low-to-high change of the frame line. With each strobe, `align_err_o` shows whether that word's frame bits differed from this pattern.
- R6: Each one-cycle pulse on `bitslip_i` moves the assumed word boundary by one bit position. From any starting phase, at most L-1 pulses reach alignment, where L is the number of bits per lane per word (12 or 6). L pulses applied to an aligned stream bring it back to alignment.
- R7: While synchronous reset is high, `valid_o`, `sample_o` and `align_err_o` go to zero after the next clock edge. `sample_o` and `align_err_o` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data is taken on both edges |
| rst | input | 1 | Synchronous reset, active high |
| two_wire_i | input | 1 | Lane mode: 0 one lane per sample, 1 odd/even split over two lanes; static outside reset |
| lane0_i | input | 1 | Serial data lane 0 (whole sample, or odd-indexed bits) |
| lane1_i | input | 1 | Serial data lane 1 (even-indexed bits; unused in one-wire mode) |
| frame_i | input | 1 | ADC frame line, sampled as data |
| bitslip_i | input | 1 | One-cycle pulse moves the word boundary by one bit |
| sample_o | output | SAMPLE_W | Rebuilt parallel sample |
| valid_o | output | 1 | One-cycle strobe for each new sample |
| align_err_o | output | 1 | Frame pattern of the latest word did not match |

## Verification
The bench builds the block with its default width of 12 bits. At that width the sample space is small enough to cover in full. It sends a stream whose consecutive words step by an odd constant. Every one of the 4096 codes therefore passes through each lane mode, and each received word can be checked against its predecessor by simple arithmetic. The two-wire run starts the stream one bit off the pair boundary. Between the two runs, bitslip therefore has to search both even and odd boundary phases. Short frame faults and full cycles of bitslip pulses at the 12-bit and 6-bit lane lengths cover the alignment-error path.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;

    typedef enum logic {
        LANES_ONE = 1'b0,
        LANES_TWO = 1'b1
    } lane_mode_e;

    // One bit-clock cycle of a DDR lane: the rising-edge bit comes first.
    typedef struct packed {
        logic early;
        logic late;
    } bit_pair_t;

    // Expected frame bits for a lane word of len bits, first bit in the MSB:
    // the upper half is high and the lower half is low.
    function automatic logic [31:0] frame_ref(input int len);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < len && i >= len / 2) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_ddr_capture.sv
module adc_ddr_capture
    import adc_deser_pkg::*;
#(
    parameter int N = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic      [N-1:0]      din,
    output bit_pair_t [N-1:0]      pair_o
);

    logic [N-1:0] rise_q;
    logic [N-1:0] fall_q;

    always_ff @(posedge clk) begin
        if (rst) rise_q <= '0;
        else     rise_q <= din;
    end

    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= din;
    end

    // Re-time both halves into the rising-edge domain as one pair.
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_o <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                pair_o[k].early <= rise_q[k];
                pair_o[k].late  <= fall_q[k];
            end
        end
    end

endmodule

// File: rtl/adc_word_aligner.sv
module adc_word_aligner
    import adc_deser_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int LANES    = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  lane_mode_e                       mode_i,
    input  logic                             bitslip_i,
    input  bit_pair_t [LANES-1:0]            pair_i,
    output logic                             word_end_o,
    output logic [LANES-1:0][SAMPLE_W-1:0]   word_o
);

    localparam int LEN_ONE = SAMPLE_W;
    localparam int LEN_TWO = SAMPLE_W / 2;
    localparam int HIST_W  = SAMPLE_W + 1;
    localparam int CNT_W   = $clog2(SAMPLE_W + 3);
    localparam logic [SAMPLE_W-1:0] HALF_MASK =
        {{(SAMPLE_W - LEN_TWO){1'b0}}, {LEN_TWO{1'b1}}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] sum;
    logic             end_older;
    logic             end_newer;
    logic             end_q;
    logic             older_q;
    logic [LANES-1:0][HIST_W-1:0] hist_q;
    logic [SAMPLE_W-1:0] len_mask;

    // cnt_q is the in-word index of the earlier bit of the incoming pair.
    always_comb begin
        len       = (mode_i == LANES_TWO) ? CNT_W'(LEN_TWO) : CNT_W'(LEN_ONE);
        end_older = (cnt_q == len - CNT_W'(1));
        end_newer = (cnt_q == len - CNT_W'(2));
        sum       = cnt_q + CNT_W'(2) + CNT_W'(bitslip_i);
        cnt_d     = (sum >= len) ? sum - len : sum;
        len_mask  = (mode_i == LANES_TWO) ? HALF_MASK : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            end_q   <= 1'b0;
            older_q <= 1'b0;
            hist_q  <= '0;
        end else begin
            cnt_q   <= cnt_d;
            end_q   <= end_older | end_newer;
            older_q <= end_older;
            for (int k = 0; k < LANES; k++) begin
                hist_q[k] <= {hist_q[k][HIST_W-3:0], pair_i[k].early, pair_i[k].late};
            end
        end
    end

    assign word_end_o = end_q;

    // When the word ended on the earlier bit, the newest bit belongs to the next word.
    for (genvar k = 0; k < LANES; k++) begin : g_extract
        logic [HIST_W-1:0] sh;
        assign sh        = older_q ? (hist_q[k] >> 1) : hist_q[k];
        assign word_o[k] = sh[SAMPLE_W-1:0] & len_mask;
    end

endmodule

// File: rtl/adc_word_merge.sv
module adc_word_merge
    import adc_deser_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  lane_mode_e           mode_i,
    input  logic [SAMPLE_W-1:0]  odd_w_i,
    input  logic [SAMPLE_W-1:0]  even_w_i,
    input  logic [SAMPLE_W-1:0]  frame_w_i,
    output logic [SAMPLE_W-1:0]  sample_o,
    output logic                 frame_ok_o
);

    localparam int HALF = SAMPLE_W / 2;

    logic [31:0] ref_one;
    logic [31:0] ref_two;
    logic [SAMPLE_W-1:0] ref_sel;

    assign ref_one = frame_ref(SAMPLE_W);
    assign ref_two = frame_ref(HALF);

    always_comb begin
        sample_o = '0;
        if (mode_i == LANES_TWO) begin
            for (int i = 0; i < HALF; i++) begin
                sample_o[2*i+1] = odd_w_i[i];
                sample_o[2*i]   = even_w_i[i];
            end
            ref_sel = ref_two[SAMPLE_W-1:0];
        end else begin
            sample_o = odd_w_i;
            ref_sel  = ref_one[SAMPLE_W-1:0];
        end
        frame_ok_o = (frame_w_i == ref_sel);
    end

endmodule

// File: rtl/lvds_adc_deser.sv
module lvds_adc_deser
    import adc_deser_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 two_wire_i,
    input  logic                 lane0_i,
    input  logic                 lane1_i,
    input  logic                 frame_i,
    input  logic                 bitslip_i,
    output logic [SAMPLE_W-1:0]  sample_o,
    output logic                 valid_o,
    output logic                 align_err_o
);

    localparam int LANES = 3;

    if (SAMPLE_W % 4 != 0 || SAMPLE_W < 8) begin : g_bad_width
        $error("SAMPLE_W must be a multiple of 4 and at least 8");
    end

    lane_mode_e                      mode;
    bit_pair_t [LANES-1:0]           pairs;
    logic                            word_end;
    logic [LANES-1:0][SAMPLE_W-1:0]  words;
    logic [SAMPLE_W-1:0]             merged;
    logic                            frame_ok;

    assign mode = lane_mode_e'(two_wire_i);

    adc_ddr_capture #(.N(LANES)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .din    ({frame_i, lane1_i, lane0_i}),
        .pair_o (pairs)
    );

    adc_word_aligner #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_align (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .bitslip_i  (bitslip_i),
        .pair_i     (pairs),
        .word_end_o (word_end),
        .word_o     (words)
    );

    adc_word_merge #(.SAMPLE_W(SAMPLE_W)) u_merge (
        .mode_i     (mode),
        .odd_w_i    (words[0]),
        .even_w_i   (words[1]),
        .frame_w_i  (words[2]),
        .sample_o   (merged),
        .frame_ok_o (frame_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o    <= '0;
            valid_o     <= 1'b0;
            align_err_o <= 1'b0;
        end else begin
            valid_o <= word_end;
            if (word_end) begin
                sample_o    <= merged;
                align_err_o <= ~frame_ok;
            end
        end
    end

endmodule

// File: rtl/lvds_adc_deser_chk.sv
module lvds_adc_deser_chk #(
    parameter int SAMPLE_W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                two_wire_i,
    input logic                bitslip_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                valid_o,
    input logic                align_err_o
);

    localparam int GAP_ONE = SAMPLE_W / 2;
    localparam int GAP_TWO = SAMPLE_W / 4;

    logic [7:0] gap_q;
    logic       seen_q;
    logic       slip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            slip_q <= 1'b0;
        end else begin
            if (valid_o)            gap_q <= 8'd1;
            else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
            if (valid_o) seen_q <= 1'b1;
            slip_q <= valid_o ? bitslip_i : (slip_q | bitslip_i);
        end
    end

    // R7
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!valid_o && !align_err_o && sample_o == '0));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R4
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && seen_q && !slip_q) |->
            (gap_q == (two_wire_i ? 8'(GAP_TWO) : 8'(GAP_ONE))));

    // R7
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(sample_o) && $stable(align_err_o)));

endmodule

bind lvds_adc_deser lvds_adc_deser_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .two_wire_i  (two_wire_i),
    .bitslip_i   (bitslip_i),
    .sample_o    (sample_o),
    .valid_o     (valid_o),
    .align_err_o (align_err_o)
);

// File: tb/lvds_adc_deser_test.sv
module lvds_adc_deser_test;

    localparam int W    = 12;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         two_wire = 1'b0;
    logic         lane0 = 1'b0;
    logic         lane1 = 1'b0;
    logic         frame = 1'b0;
    logic         bitslip = 1'b0;
    logic [W-1:0] sample;
    logic         valid;
    logic         align_err;

    int total = 0;
    int bad = 0;
    int g = 0;
    int bad_n = -1;
    bit restart = 1'b0;
    int restart_off = 0;

    always #10 clk = ~clk;

    lvds_adc_deser #(.SAMPLE_W(W)) uut (
        .clk         (clk),
        .rst         (rst),
        .two_wire_i  (two_wire),
        .lane0_i     (lane0),
        .lane1_i     (lane1),
        .frame_i     (frame),
        .bitslip_i   (bitslip),
        .sample_o    (sample),
        .valid_o     (valid),
        .align_err_o (align_err)
    );

    function automatic int word_len();
        return two_wire ? W / 2 : W;
    endfunction

    function automatic int sample_of(input int n);
        return (n * 5 + 7) & MASK;
    endfunction

    function automatic logic stream_bit(input int lane, input int gi);
        int L, n, i;
        logic [W-1:0] v;
        logic [31:0] h;
        L = word_len();
        n = gi / L;
        i = gi % L;
        v = W'(sample_of(n));
        h = 32'(gi) * 32'h9E3779B1;
        case (lane)
            0:       return two_wire ? v[W-1-2*i] : v[W-1-i];
            1:       return two_wire ? v[W-2-2*i] : h[13];
            default: return ((i < L / 2) ? 1'b1 : 1'b0) ^ (n == bad_n);
        endcase
    endfunction

    // Serial source: earlier bit before the rising edge, later bit before the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (restart) begin
                g = restart_off;
                restart = 1'b0;
            end
            #1;
            lane0 = stream_bit(0, g);
            lane1 = stream_bit(1, g);
            frame = stream_bit(2, g);
            @(posedge clk);
            #1;
            lane0 = stream_bit(0, g + 1);
            lane1 = stream_bit(1, g + 1);
            frame = stream_bit(2, g + 1);
            g = g + 2;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!valid && cyc < 1000);
        if (!valid) chk(1'b0, "R4 strobe missing", 0, 1);
    endtask

    task automatic pulse_slip();
        bitslip = 1'b1;
        @(negedge clk);
        bitslip = 1'b0;
    endtask

    task automatic skip_words(input int n);
        int c;
        for (int k = 0; k < n; k++) wait_valid(c);
    endtask

    task automatic reset_phase(input bit mode, input int off);
        @(negedge clk);
        rst = 1'b1;
        two_wire = mode;
        restart_off = off;
        restart = 1'b1;
        repeat (4) @(negedge clk);
        chk(valid == 1'b0, "R7 valid in reset", int'(valid), 0);
        chk(sample == '0, "R7 sample in reset", int'(sample), 0);
        chk(align_err == 1'b0, "R7 error flag in reset", int'(align_err), 0);
        rst = 1'b0;
    endtask

    task automatic lock(output int slips);
        slips = 0;
        skip_words(3);
        while (align_err && slips < 2 * W) begin
            pulse_slip();
            slips++;
            skip_words(3);
        end
    endtask

    task automatic sweep(input int nwords);
        int c, prev, L;
        string dmsg;
        L = word_len();
        dmsg = two_wire ? "R3 two-wire merge with R1 bit order"
                        : "R2 one-wire with lane1 ignored and R1 bit order";
        wait_valid(c);
        prev = int'(sample);
        for (int k = 0; k < nwords; k++) begin
            @(negedge clk);
            chk(valid == 1'b0, "R4 strobe lasts one cycle", int'(valid), 0);
            wait_valid(c);
            chk(c + 1 == L / 2, "R4 strobe spacing", c + 1, L / 2);
            chk(align_err == 1'b0, "R5 aligned frame accepted", int'(align_err), 0);
            chk(int'(sample) == ((prev + 5) & MASK), dmsg, int'(sample), (prev + 5) & MASK);
            prev = int'(sample);
        end
    endtask

    task automatic slip_cycle();
        int L;
        L = word_len();
        pulse_slip();
        skip_words(3);
        chk(align_err == 1'b1, "R6 one slip breaks alignment", int'(align_err), 1);
        for (int j = 0; j < L - 1; j++) begin
            pulse_slip();
            skip_words(3);
        end
        chk(align_err == 1'b0, "R6 full cycle of slips restores alignment", int'(align_err), 0);
        sweep(20);
    endtask

    task automatic bad_frame();
        int c, hit, bv;
        bit e;
        bad_n = g / word_len() + 4;
        bv = sample_of(bad_n);
        hit = 0;
        for (int j = 0; j < 10; j++) begin
            wait_valid(c);
            e = (int'(sample) == bv);
            chk(align_err == e, "R5 frame fault flagged on its word only", int'(align_err), int'(e));
            if (e) hit++;
        end
        chk(hit == 1, "R5 faulty word seen once", hit, 1);
        bad_n = -1;
        skip_words(2);
    endtask

    task automatic run_mode(input bit mode, input int off);
        int slips;
        reset_phase(mode, off);
        lock(slips);
        chk(slips <= word_len() - 1, "R6 lock within L-1 slips", slips, word_len() - 1);
        sweep(4096);
        slip_cycle();
        bad_frame();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        run_mode(1'b0, 0);
        run_mode(1'b1, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule